// File: doc/BRIEF.md
# SMBus Combined-Transfer Sequencer

This block runs one SMBus transaction at a time on top of a byte-level I2C master. The master handles bit timing and start, stop and acknowledge signalling on the wire. The sequencer decides which byte goes out next, when a repeated START is needed, and when the final read byte must be NACKed. It also decides when the transfer is over and how it ended. It supports five transfer kinds: quick, plain byte, byte-data, word-data and I2C-block. A request carries a 7-bit target address, a direction flag, a command byte and a block length.

After a request is accepted, the sequencer issues a START. It then advances one step on each status event that the master reports. Outgoing data is fetched from an external byte buffer by index. Incoming data is written back by index. Index 0 holds the low byte of a word. A transfer ends with a one-cycle done pulse and a 2-bit result: 0 success, 1 no device, 2 I/O error, 3 rejected request. A reset-needed flag is raised when the master itself must be reinitialised.

A transaction is abandoned as an I/O error if the master raises no event within a timeout. The timeout is 200 ms, measured in cycles of a clock whose frequency is a parameter.

Top module: `smbus_xfer_seq`

## Requirements
- R1: An accepted request (kind_i encoding: 0 quick, 1 byte, 2 byte-data, 3 word-data, 4 block) raises start_o for one cycle and busy_o on the next clock edge. The address byte is {addr_i, rd_i}, with the direction in bit 0 (1 = read).
- R2: For byte-data, word-data and block transfers, the first two bytes sent are the address byte with bit 0 cleared, followed by cmd_i.
- R3: After the command byte of a read, the next event produces start_o together with tx_we_o carrying the address byte with bit 0 set. After the command byte of a write, data bytes follow with no second START.
- R4: Quick and plain-byte transfers send the address byte with its real direction bit as the first byte, with no command phase. A plain-byte write then sends cmd_i as its single data byte.
- R5: During a read, ack_arm_o (1 = NACK the next byte) is high only while the final byte is being received. It is set on entering the read phase when exactly one byte is wanted, and otherwise on the event that delivers the second-to-last byte.
- R6: Each read event writes rx_byte_i to rx_data_o at rx_idx_o, with indices counting up from 0. The event that delivers the last byte also pulses stop_o and done_o with result 0.
- R7: Write data is taken from buf_data_i at buf_idx_o, with indices counting up from 0. The event after the last data byte pulses stop_o and done_o with result 0.
- R8: An event with nack_i set, in any state, pulses stop_o, clr_stat_o and done_o, gives result 1 and leaves need_rst_o low.
- R9: An event with bus_err_i set or master_i low gives result 2 with done_o and no stop_o, and sets need_rst_o. need_rst_o is cleared only by the next accepted request.
- R10: If no event arrives for CLK_HZ/1000*TIMEOUT_MS cycles while busy, the transfer ends with result 2 and need_rst_o set.
- R11: A quick read, a block length of 0 or above BLK_MAX, or a kind code above 4 is rejected. done_o pulses with result 3 on the next edge, and neither start_o nor busy_o is raised.
- R12: busy_o stays high from acceptance until the edge that pulses done_o, and requests are ignored while it is high. result_o changes only together with done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transaction request pulse |
| kind_i | input | 3 | Transfer kind code |
| rd_i | input | 1 | Direction, 1 = read |
| addr_i | input | 7 | Target address |
| cmd_i | input | 8 | Command byte |
| len_i | input | LEN_W | Block length (block kind only) |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | Completion pulse |
| result_o | output | 2 | Completion code |
| need_rst_o | output | 1 | Master needs reinitialisation |
| evt_i | input | 1 | Master status event pulse |
| nack_i | input | 1 | Negative acknowledge seen |
| bus_err_i | input | 1 | Bus error seen |
| master_i | input | 1 | Master still owns the bus |
| rx_byte_i | input | 8 | Byte received by the master |
| start_o | output | 1 | Request (repeated) START |
| stop_o | output | 1 | Request STOP |
| ack_arm_o | output | 1 | NACK the next received byte |
| clr_stat_o | output | 1 | Clear NACK and stall status |
| tx_we_o | output | 1 | Load tx_byte_o into the master |
| tx_byte_o | output | 8 | Byte to send |
| buf_idx_o | output | LEN_W | Write buffer index |
| buf_data_i | input | 8 | Write buffer data at buf_idx_o |
| rx_we_o | output | 1 | Store received byte |
| rx_idx_o | output | LEN_W | Read buffer index |
| rx_data_o | output | 8 | Received byte |

## Verification
Every action the sequencer takes, including done_o and result_o, is registered. It appears on the clock edge that samples the request or event, exactly one cycle later. The bench drives inputs on the falling edge, holds an event for one rising edge, and reads all outputs on the next falling edge, so each event is paired with exactly the actions it caused. The timeout is checked as a window: there must be no completion well before the limit and a completion shortly after it. Rejected requests are checked on the first falling edge after the request.

// File: rtl/smbus_seq_pkg.sv
package smbus_seq_pkg;
  typedef enum logic [2:0] {
    K_QUICK = 3'd0, K_BYTE = 3'd1, K_BDATA = 3'd2, K_WORD = 3'd3, K_BLOCK = 3'd4
  } kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_RSTART, ST_QUICK, ST_READ, ST_WRITE
  } seq_state_e;

  localparam logic [1:0] RES_OK    = 2'd0;
  localparam logic [1:0] RES_NODEV = 2'd1;
  localparam logic [1:0] RES_IOERR = 2'd2;
  localparam logic [1:0] RES_INVAL = 2'd3;
endpackage

// File: rtl/smbus_seq_req.sv
module smbus_seq_req
  import smbus_seq_pkg::*;
#(
  parameter int BLK_MAX = 32,
  parameter int LEN_W   = $clog2(BLK_MAX + 1)
) (
  input  logic [2:0]       kind_i,
  input  logic             rd_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             ok_o,
  output logic             quick_o,
  output logic             cmd_data_o,
  output logic [LEN_W-1:0] xlen_o
);
  always_comb begin
    ok_o       = 1'b1;
    quick_o    = 1'b0;
    cmd_data_o = 1'b0;
    xlen_o     = '0;
    unique case (kind_i)
      K_QUICK: begin
        quick_o = 1'b1;
        ok_o    = !rd_i;
      end
      K_BYTE: begin
        quick_o    = 1'b1;
        cmd_data_o = !rd_i;
        xlen_o     = LEN_W'(1);
      end
      K_BDATA: xlen_o = LEN_W'(1);
      K_WORD:  xlen_o = LEN_W'(2);
      K_BLOCK: begin
        xlen_o = len_i;
        ok_o   = (len_i != '0) && (int'(len_i) <= BLK_MAX);
      end
      default: ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/smbus_seq_timer.sv
module smbus_seq_timer #(
  parameter int TO_CYC = 1000,
  parameter int CNT_W  = $clog2(TO_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic kick_i,
  output logic expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (kick_i || !run_i)  cnt_q <= '0;
    else if (!expire_o)         cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && !kick_i && (cnt_q == CNT_W'(TO_CYC - 1));
endmodule

// File: rtl/smbus_seq_fsm.sv
module smbus_seq_fsm
  import smbus_seq_pkg::*;
#(
  parameter int LEN_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             ok_i,
  input  logic             quick_i,
  input  logic             cmd_data_i,
  input  logic [LEN_W-1:0] xlen_i,
  input  logic             rd_i,
  input  logic [6:0]       addr_i,
  input  logic [7:0]       cmd_i,
  input  logic             evt_i,
  input  logic             nack_i,
  input  logic             bus_err_i,
  input  logic             master_i,
  input  logic [7:0]       rx_byte_i,
  input  logic             expire_i,
  input  logic [7:0]       buf_data_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       result_o,
  output logic             need_rst_o,
  output logic             start_o,
  output logic             stop_o,
  output logic             ack_arm_o,
  output logic             clr_stat_o,
  output logic             tx_we_o,
  output logic [7:0]       tx_byte_o,
  output logic [LEN_W-1:0] buf_idx_o,
  output logic             rx_we_o,
  output logic [LEN_W-1:0] rx_idx_o,
  output logic [7:0]       rx_data_o
);
  seq_state_e       state_q;
  logic [7:0]       abyte_q, cmd_q;
  logic [LEN_W-1:0] len_q, idx_q;
  logic             cmd_data_q;

  assign busy_o    = (state_q != ST_IDLE);
  assign buf_idx_o = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      abyte_q    <= '0;
      cmd_q      <= '0;
      len_q      <= '0;
      idx_q      <= '0;
      cmd_data_q <= 1'b0;
      done_o     <= 1'b0;
      result_o   <= RES_OK;
      need_rst_o <= 1'b0;
      start_o    <= 1'b0;
      stop_o     <= 1'b0;
      ack_arm_o  <= 1'b0;
      clr_stat_o <= 1'b0;
      tx_we_o    <= 1'b0;
      tx_byte_o  <= '0;
      rx_we_o    <= 1'b0;
      rx_idx_o   <= '0;
      rx_data_o  <= '0;
    end else begin
      done_o     <= 1'b0;
      start_o    <= 1'b0;
      stop_o     <= 1'b0;
      clr_stat_o <= 1'b0;
      tx_we_o    <= 1'b0;
      rx_we_o    <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (req_i) begin
          if (!ok_i) begin
            done_o   <= 1'b1;
            result_o <= RES_INVAL;
          end else begin
            state_q    <= quick_i ? ST_QUICK : ST_ADDR;
            start_o    <= 1'b1;
            abyte_q    <= {addr_i, rd_i};
            cmd_q      <= cmd_i;
            len_q      <= xlen_i;
            idx_q      <= '0;
            cmd_data_q <= cmd_data_i;
            need_rst_o <= 1'b0;
            ack_arm_o  <= 1'b0;
          end
        end
      end else if (evt_i) begin
        if (bus_err_i || !master_i) begin
          state_q    <= ST_IDLE;
          done_o     <= 1'b1;
          result_o   <= RES_IOERR;
          need_rst_o <= 1'b1;
        end else if (nack_i) begin
          state_q    <= ST_IDLE;
          done_o     <= 1'b1;
          result_o   <= RES_NODEV;
          stop_o     <= 1'b1;
          clr_stat_o <= 1'b1;
        end else begin
          unique case (state_q)
            ST_ADDR: begin
              tx_we_o   <= 1'b1;
              tx_byte_o <= {abyte_q[7:1], 1'b0};
              state_q   <= ST_CMD;
            end
            ST_CMD: begin
              tx_we_o   <= 1'b1;
              tx_byte_o <= cmd_q;
              state_q   <= abyte_q[0] ? ST_RSTART : ST_WRITE;
            end
            ST_RSTART, ST_QUICK: begin
              // repeated start shares the address phase of the quick path
              start_o   <= (state_q == ST_RSTART);
              tx_we_o   <= 1'b1;
              tx_byte_o <= abyte_q;
              if (abyte_q[0]) begin
                ack_arm_o <= (len_q == LEN_W'(1));
                state_q   <= ST_READ;
              end else begin
                state_q   <= ST_WRITE;
              end
            end
            ST_READ: begin
              ack_arm_o <= (len_q == LEN_W'(2));
              rx_we_o   <= 1'b1;
              rx_idx_o  <= idx_q;
              rx_data_o <= rx_byte_i;
              idx_q     <= idx_q + 1'b1;
              len_q     <= len_q - 1'b1;
              if (len_q == LEN_W'(1)) begin
                state_q  <= ST_IDLE;
                done_o   <= 1'b1;
                result_o <= RES_OK;
                stop_o   <= 1'b1;
              end
            end
            ST_WRITE: begin
              if (len_q == '0) begin
                state_q  <= ST_IDLE;
                done_o   <= 1'b1;
                result_o <= RES_OK;
                stop_o   <= 1'b1;
              end else begin
                tx_we_o   <= 1'b1;
                tx_byte_o <= cmd_data_q ? cmd_q : buf_data_i;
                idx_q     <= idx_q + 1'b1;
                len_q     <= len_q - 1'b1;
              end
            end
            default: state_q <= ST_IDLE;
          endcase
        end
      end else if (expire_i) begin
        state_q    <= ST_IDLE;
        done_o     <= 1'b1;
        result_o   <= RES_IOERR;
        need_rst_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/smbus_xfer_seq.sv
module smbus_xfer_seq
  import smbus_seq_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int TIMEOUT_MS = 200,
  parameter int BLK_MAX    = 32,
  parameter int LEN_W      = $clog2(BLK_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [2:0]       kind_i,
  input  logic             rd_i,
  input  logic [6:0]       addr_i,
  input  logic [7:0]       cmd_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       result_o,
  output logic             need_rst_o,
  input  logic             evt_i,
  input  logic             nack_i,
  input  logic             bus_err_i,
  input  logic             master_i,
  input  logic [7:0]       rx_byte_i,
  output logic             start_o,
  output logic             stop_o,
  output logic             ack_arm_o,
  output logic             clr_stat_o,
  output logic             tx_we_o,
  output logic [7:0]       tx_byte_o,
  output logic [LEN_W-1:0] buf_idx_o,
  input  logic [7:0]       buf_data_i,
  output logic             rx_we_o,
  output logic [LEN_W-1:0] rx_idx_o,
  output logic [7:0]       rx_data_o
);
  localparam int TO_CYC = (CLK_HZ / 1000) * TIMEOUT_MS;

  logic             ok, quick, cmd_data, expire;
  logic [LEN_W-1:0] xlen;

  smbus_seq_req #(.BLK_MAX(BLK_MAX), .LEN_W(LEN_W)) u_req (
    .kind_i(kind_i), .rd_i(rd_i), .len_i(len_i),
    .ok_o(ok), .quick_o(quick), .cmd_data_o(cmd_data), .xlen_o(xlen)
  );

  smbus_seq_timer #(.TO_CYC(TO_CYC)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(busy_o),
    .kick_i(evt_i), .expire_o(expire)
  );

  smbus_seq_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .ok_i(ok),
    .quick_i(quick), .cmd_data_i(cmd_data), .xlen_i(xlen),
    .rd_i(rd_i), .addr_i(addr_i), .cmd_i(cmd_i),
    .evt_i(evt_i), .nack_i(nack_i), .bus_err_i(bus_err_i),
    .master_i(master_i), .rx_byte_i(rx_byte_i), .expire_i(expire),
    .buf_data_i(buf_data_i), .busy_o(busy_o), .done_o(done_o),
    .result_o(result_o), .need_rst_o(need_rst_o), .start_o(start_o),
    .stop_o(stop_o), .ack_arm_o(ack_arm_o), .clr_stat_o(clr_stat_o),
    .tx_we_o(tx_we_o), .tx_byte_o(tx_byte_o), .buf_idx_o(buf_idx_o),
    .rx_we_o(rx_we_o), .rx_idx_o(rx_idx_o), .rx_data_o(rx_data_o)
  );
endmodule

// File: rtl/smbus_xfer_seq_sva.sv
module smbus_xfer_seq_sva
  import smbus_seq_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       evt_i,
  input logic       busy_o,
  input logic       done_o,
  input logic [1:0] result_o,
  input logic       need_rst_o,
  input logic       start_o,
  input logic       stop_o,
  input logic       tx_we_o,
  input logic       rx_we_o
);
  assert_done_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_result_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));
  assert_start_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> busy_o);
  assert_stop_ends_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> done_o);
  assert_rst_ioerr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(need_rst_o) |-> (result_o == RES_IOERR));
  assert_rx_evt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_we_o |-> $past(evt_i));
  assert_tx_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_we_o |-> busy_o);
endmodule

bind smbus_xfer_seq smbus_xfer_seq_sva u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .busy_o(busy_o),
  .done_o(done_o), .result_o(result_o), .need_rst_o(need_rst_o),
  .start_o(start_o), .stop_o(stop_o), .tx_we_o(tx_we_o), .rx_we_o(rx_we_o)
);

// File: tb/tb_smbus_xfer_seq.sv
module tb_smbus_xfer_seq;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W      = 6;
  localparam int TO_CYC     = 200;

  typedef struct packed {
    logic [2:0] kind; logic rd; logic [6:0] addr; logic [7:0] cmd; logic [5:0] len;
    logic [1:0] res; logic [7:0] evts; logic [7:0] ntx;
    logic [7:0] tx0; logic [7:0] tx1; logic [7:0] tx2; logic [7:0] nrx; logic [1:0] starts;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VEC [NVEC] = '{
    '{3'd0, 1'b0, 7'h50, 8'h00, 6'd0,  2'd0, 8'd2,  8'd1, 8'hA0, 8'h00, 8'h00, 8'd0,  2'd1},
    '{3'd1, 1'b0, 7'h50, 8'h3C, 6'd0,  2'd0, 8'd3,  8'd2, 8'hA0, 8'h3C, 8'h00, 8'd0,  2'd1},
    '{3'd1, 1'b1, 7'h50, 8'h00, 6'd0,  2'd0, 8'd2,  8'd1, 8'hA1, 8'h00, 8'h00, 8'd1,  2'd1},
    '{3'd2, 1'b0, 7'h50, 8'h10, 6'd0,  2'd0, 8'd4,  8'd3, 8'hA0, 8'h10, 8'hB0, 8'd0,  2'd1},
    '{3'd3, 1'b1, 7'h50, 8'h22, 6'd0,  2'd0, 8'd5,  8'd3, 8'hA0, 8'h22, 8'hA1, 8'd2,  2'd2},
    '{3'd3, 1'b0, 7'h50, 8'h22, 6'd0,  2'd0, 8'd5,  8'd4, 8'hA0, 8'h22, 8'hB0, 8'd0,  2'd1},
    '{3'd4, 1'b0, 7'h2A, 8'h05, 6'd3,  2'd0, 8'd6,  8'd5, 8'h54, 8'h05, 8'hB0, 8'd0,  2'd1},
    '{3'd4, 1'b1, 7'h7F, 8'h01, 6'd32, 2'd0, 8'd35, 8'd3, 8'hFE, 8'h01, 8'hFF, 8'd32, 2'd2},
    '{3'd0, 1'b1, 7'h50, 8'h00, 6'd0,  2'd3, 8'd0,  8'd0, 8'h00, 8'h00, 8'h00, 8'd0,  2'd0},
    '{3'd4, 1'b0, 7'h50, 8'h00, 6'd0,  2'd3, 8'd0,  8'd0, 8'h00, 8'h00, 8'h00, 8'd0,  2'd0},
    '{3'd4, 1'b1, 7'h50, 8'h00, 6'd33, 2'd3, 8'd0,  8'd0, 8'h00, 8'h00, 8'h00, 8'd0,  2'd0},
    '{3'd5, 1'b0, 7'h50, 8'h00, 6'd1,  2'd3, 8'd0,  8'd0, 8'h00, 8'h00, 8'h00, 8'd0,  2'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, rd = 1'b0, evt = 1'b0, nack = 1'b0, berr = 1'b0, mst = 1'b1;
  logic [2:0] kind = '0;
  logic [6:0] addr = '0;
  logic [7:0] cmd = '0, rxb = '0;
  logic [LEN_W-1:0] len = '0;
  logic busy, done, need_rst, start, stop, ack_arm, clr_stat, tx_we, rx_we;
  logic [1:0] result;
  logic [7:0] tx_byte, rx_data, buf_data;
  logic [LEN_W-1:0] buf_idx, rx_idx;
  int checks = 0, errors = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign buf_data = 8'hB0 ^ {2'b00, buf_idx};

  smbus_xfer_seq #(.CLK_HZ(1000), .TIMEOUT_MS(TO_CYC), .BLK_MAX(32)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .kind_i(kind), .rd_i(rd),
    .addr_i(addr), .cmd_i(cmd), .len_i(len), .busy_o(busy), .done_o(done),
    .result_o(result), .need_rst_o(need_rst), .evt_i(evt), .nack_i(nack),
    .bus_err_i(berr), .master_i(mst), .rx_byte_i(rxb), .start_o(start),
    .stop_o(stop), .ack_arm_o(ack_arm), .clr_stat_o(clr_stat), .tx_we_o(tx_we),
    .tx_byte_o(tx_byte), .buf_idx_o(buf_idx), .buf_data_i(buf_data),
    .rx_we_o(rx_we), .rx_idx_o(rx_idx), .rx_data_o(rx_data)
  );

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req_tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] k, input logic r, input logic [6:0] a,
                       input logic [7:0] c, input logic [LEN_W-1:0] l);
    kind = k; rd = r; addr = a; cmd = c; len = l; req = 1'b1;
    @(posedge clk); @(negedge clk);
    req = 1'b0;
  endtask

  task automatic pulse(input logic n, input logic b, input logic m, input logic [7:0] d);
    nack = n; berr = b; mst = m; rxb = d; evt = 1'b1;
    @(posedge clk); @(negedge clk);
    evt = 1'b0; nack = 1'b0; berr = 1'b0; mst = 1'b1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 reset busy", busy, 0);
    chk("R12 reset done", done, 0);
    chk("R9 reset need_rst", need_rst, 0);
    chk("R1 reset start", start, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      vec_t e;
      int nev, ntx, nrx, nst, narm;
      logic [7:0] txl [8];
      logic last_arm, a;
      e = VEC[v];
      nev = 0; ntx = 0; nrx = 0; nst = 0; narm = 0; last_arm = 1'b0;
      for (int i = 0; i < 8; i++) txl[i] = '0;
      issue(e.kind, e.rd, e.addr, e.cmd, e.len);
      if (e.res == 2'd3) begin
        chk($sformatf("R11 vec%0d done", v), done, 1);
        chk($sformatf("R11 vec%0d result", v), result, 3);
        chk($sformatf("R11 vec%0d no start", v), {start, busy}, 0);
        continue;
      end
      chk($sformatf("R1 vec%0d start+busy", v), {start, busy}, 2'b11);
      nst = 1;
      while (!done && nev < 60) begin
        a = ack_arm;
        pulse(1'b0, 1'b0, 1'b1, 8'h40 + 8'(nev));
        nev++;
        if (start) begin
          nst++;
          chk($sformatf("R3 vec%0d restart addr", v), {tx_we, tx_byte[0]}, 2'b11);
        end
        if (tx_we) begin
          if (ntx < 8) txl[ntx] = tx_byte;
          ntx++;
        end
        if (rx_we) begin
          chk($sformatf("R6 vec%0d rx idx", v), rx_idx, nrx);
          chk($sformatf("R6 vec%0d rx data", v), rx_data, 8'h40 + 8'(nev - 1));
          if (a) narm++;
          last_arm = a;
          nrx++;
        end
      end
      chk($sformatf("R6 R7 vec%0d result", v), {done, stop, result}, {2'b11, e.res});
      chk($sformatf("R7 vec%0d events", v), nev, e.evts);
      chk($sformatf("R2 R4 vec%0d tx count", v), ntx, e.ntx);
      chk($sformatf("R2 R4 vec%0d tx0", v), txl[0], e.tx0);
      if (e.ntx > 1) chk($sformatf("R2 R4 vec%0d tx1", v), txl[1], e.tx1);
      if (e.ntx > 2) chk($sformatf("R3 R7 vec%0d tx2", v), txl[2], e.tx2);
      chk($sformatf("R6 vec%0d rx count", v), nrx, e.nrx);
      chk($sformatf("R3 vec%0d starts", v), nst, e.starts);
      if (e.nrx > 0) chk($sformatf("R5 vec%0d ack arm", v), {narm, last_arm}, {32'd1, 1'b1});
      @(negedge clk);
    end

    // R7 block write data order: second data byte from index 1
    issue(3'd4, 1'b0, 7'h11, 8'h00, 6'd2);
    pulse(0, 0, 1, 0); pulse(0, 0, 1, 0); pulse(0, 0, 1, 0);
    pulse(0, 0, 1, 0);
    chk("R7 block idx1 byte", tx_byte, 8'hB1);
    pulse(0, 0, 1, 0);
    chk("R7 block end", {done, stop, result}, 4'b1100);

    // R8 NACK on command byte
    issue(3'd2, 1'b0, 7'h33, 8'h01, 0);
    pulse(0, 0, 1, 0);
    pulse(1, 0, 1, 0);
    chk("R8 nack actions", {done, stop, clr_stat, busy}, 4'b1110);
    chk("R8 nack result", result, 1);
    chk("R8 nack no reset", need_rst, 0);

    // R9 bus error
    issue(3'd3, 1'b1, 7'h33, 8'h01, 0);
    pulse(0, 1, 1, 0);
    chk("R9 berr actions", {done, stop, busy}, 3'b100);
    chk("R9 berr result", {result, need_rst}, {2'd2, 1'b1});
    @(negedge clk);
    chk("R9 flag held", need_rst, 1);
    issue(3'd0, 1'b0, 7'h33, 8'h00, 0);
    chk("R9 flag cleared by request", need_rst, 0);
    pulse(0, 0, 0, 0);
    chk("R9 lost master", {done, result, need_rst}, {1'b1, 2'd2, 1'b1});

    // R12 request while busy is ignored
    issue(3'd1, 1'b0, 7'h50, 8'h3C, 0);
    issue(3'd0, 1'b1, 7'h12, 8'h00, 0);
    chk("R12 busy ignores req", {done, busy, start}, 3'b010);
    pulse(0, 0, 1, 0);
    chk("R12 original addr kept", tx_byte, 8'hA0);
    pulse(0, 0, 1, 0);
    chk("R12 original data kept", tx_byte, 8'h3C);
    pulse(0, 0, 1, 0);
    chk("R12 original ends", {done, result}, 3'b100);

    // R10 timeout
    issue(3'd2, 1'b0, 7'h44, 8'h00, 0);
    begin
      int t;
      bit early;
      t = 0; early = 0;
      while (!done && t < TO_CYC + 20) begin
        @(negedge clk);
        t++;
        if (done && t < TO_CYC - 10) early = 1;
      end
      chk("R10 not early", early, 0);
      chk("R10 expired", {done, result, need_rst}, {1'b1, 2'd2, 1'b1});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule